// File: doc/BRIEF.md
# Alarm-Driven Power-Off Controller

This block is a second, independent alarm channel that can take power away from the whole system. It holds six BCD compare bytes (seconds, minutes, hours, day of month, month, year). A calendar counter elsewhere supplies the running BCD time and a one-cycle pulse once per second. On each pulse the block compares all six fields against its own compare bytes. No field can be masked. When every field agrees, a sticky status flag is raised.

If the power-control arm bit is set when the match occurs, the block also drives its power-enable output from the on level (1) to the off level (0). An external power-management device watches that output and cuts the supply. Once the output has gone off it stays off until the block is reset. An optional interrupt output reports the status flag. Software sets the block up through a simple word-wide register port with byte strobes. The usual sequence is to load the six compare bytes for a time at least two seconds ahead, set the arm bit, and then wait.

Register map (byte addresses, 32-bit words, read data is combinational on the address):
- Compare bytes: 0x80 seconds, 0x84 minutes, 0x88 hours, 0x8C day, 0x90 month, 0x94 year.
- Power control: 0x98.
- Interrupt enable: 0x9C.
- Status: 0xA0.

Top module: `pwroff_alarm_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `pwr_en` is 1, `irq` is 0, and every register (compare bytes, power control, interrupt enable, status) reads 0.
- R2: A write to 0x80, 0x84, 0x88, 0x8C, 0x90 or 0x94 with `reg_wstrb[0]` set stores `reg_wdata[7:0]` as the seconds, minutes, hours, day, month or year compare byte. It reads back in bits 7:0, and bits 31:8 read 0.
- R3: On a cycle with `tick` high in which all six current-time inputs equal their compare bytes, the status flag (bit 7 of 0xA0) reads 1 from the next cycle on. The flag does not change when `tick` is low, or when any one field differs.
- R4: The arm bit is bit 16 of 0x98, written when `reg_wstrb[2]` is set and read back in bit 16. A match while it is 1 drives `pwr_en` to 0 from the next cycle.
- R5: While the arm bit is 0, `pwr_en` stays 1 whatever the match outcome.
- R6: Once `pwr_en` is 0 it stays 0 until reset. Clearing the status flag or the arm bit does not restore it.
- R7: Writing 1 to bit 7 of 0xA0 with `reg_wstrb[0]` set clears the status flag, and writing 0 there leaves it unchanged. If a match and a clear occur in the same cycle, the flag stays set.
- R8: The interrupt enable is bit 4 of 0x9C. It is updated only by a full-word write (`reg_wstrb` = 4'hF), and a partial write leaves it unchanged. `irq` is 1 exactly when the status flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second from the calendar counter |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 8 | Current year within century, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_wstrb | input | 4 | Byte strobes for the write |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pwr_en | output | 1 | Power-enable to the external power manager, 1 = on |
| irq | output | 1 | Power-off alarm interrupt |

## Verification
A corrupted compare byte or a mismatched field index would appear in two places. It shows on the register read-back right away. It also shows as a status flag that fails to rise, or rises falsely, one cycle after the tick that should have decided it. A wrong arm or power-off latch state shows on `pwr_en` in the cycle after a match, or as a `pwr_en` that comes back on later, which the bench looks for after clearing status and arm. A lost interrupt-enable update, or one wrongly accepted, shows on `irq` and on the 0x9C read-back as soon as the write completes.

// File: rtl/pwroff_alarm_pkg.sv
package pwroff_alarm_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = $clog2(NUM_FIELDS);

    // Register layout
    localparam logic [ADDR_W-1:0] FIELD_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] ARM_ADDR   = 8'h98;
    localparam logic [ADDR_W-1:0] IE_ADDR    = 8'h9C;
    localparam logic [ADDR_W-1:0] STAT_ADDR  = 8'hA0;

    localparam int ARM_BIT  = 16;
    localparam int IE_BIT   = 4;
    localparam int STAT_BIT = 7;

    typedef logic [FIELD_W-1:0]                  bcd_t;
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0]  cal_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FIELD,
        SEL_ARM,
        SEL_IE,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic [IDX_W-1:0]   idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] addr);
        reg_dec_t            d;
        logic [ADDR_W-1:0]   off;
        off   = addr - FIELD_BASE;
        d.sel = SEL_NONE;
        d.idx = '0;
        if (addr == ARM_ADDR) begin
            d.sel = SEL_ARM;
        end else if (addr == IE_ADDR) begin
            d.sel = SEL_IE;
        end else if (addr == STAT_ADDR) begin
            d.sel = SEL_STAT;
        end else if (addr >= FIELD_BASE && off[1:0] == 2'b00 &&
                     int'(off[ADDR_W-1:2]) < NUM_FIELDS) begin
            d.sel = SEL_FIELD;
            d.idx = off[IDX_W+1:2];
        end
        return d;
    endfunction

endpackage

// File: rtl/pwroff_regfile.sv
module pwroff_regfile
    import pwroff_alarm_pkg::*;
#(
    parameter int P_FIELD_W    = FIELD_W,
    parameter int P_NUM_FIELDS = NUM_FIELDS,
    parameter int P_DATA_W     = DATA_W
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   reg_we,
    input  logic [ADDR_W-1:0]                      reg_addr,
    input  logic [P_DATA_W-1:0]                    reg_wdata,
    input  logic [P_DATA_W/8-1:0]                  reg_wstrb,
    input  logic                                   st_i,
    output logic [P_DATA_W-1:0]                    reg_rdata,
    output logic [P_NUM_FIELDS-1:0][P_FIELD_W-1:0] alarm_o,
    output logic                                   arm_o,
    output logic                                   ie_o,
    output logic                                   clr_o
);

    localparam int STRB_W = P_DATA_W / 8;

    reg_dec_t dec;
    logic     full_word;

    assign dec       = decode_addr(reg_addr);
    assign full_word = &reg_wstrb;

    // Compare bytes: one register per field, written through byte lane 0
    for (genvar g = 0; g < P_NUM_FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                alarm_o[g] <= '0;
            end else if (reg_we && dec.sel == SEL_FIELD &&
                         int'(dec.idx) == g && reg_wstrb[0]) begin
                alarm_o[g] <= reg_wdata[P_FIELD_W-1:0];
            end
        end
    end

    // Arm bit lives in byte lane 2
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_o <= 1'b0;
        end else if (reg_we && dec.sel == SEL_ARM && reg_wstrb[ARM_BIT/8]) begin
            arm_o <= reg_wdata[ARM_BIT];
        end
    end

    // Interrupt enable accepts only a whole-word write
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_o <= 1'b0;
        end else if (reg_we && dec.sel == SEL_IE && full_word) begin
            ie_o <= reg_wdata[IE_BIT];
        end
    end

    assign clr_o = reg_we && dec.sel == SEL_STAT &&
                   reg_wstrb[STAT_BIT/8] && reg_wdata[STAT_BIT];

    always_comb begin
        reg_rdata = '0;
        case (dec.sel)
            SEL_FIELD: begin
                for (int i = 0; i < P_NUM_FIELDS; i++) begin
                    if (int'(dec.idx) == i) reg_rdata[P_FIELD_W-1:0] = alarm_o[i];
                end
            end
            SEL_ARM:  reg_rdata[ARM_BIT]  = arm_o;
            SEL_IE:   reg_rdata[IE_BIT]   = ie_o;
            SEL_STAT: reg_rdata[STAT_BIT] = st_i;
            default:  reg_rdata = '0;
        endcase
    end

    logic unused_strb;
    assign unused_strb = ^{reg_wstrb[STRB_W-1:0], 1'b0};

endmodule

// File: rtl/pwroff_match.sv
module pwroff_match
    import pwroff_alarm_pkg::*;
#(
    parameter int P_FIELD_W    = FIELD_W,
    parameter int P_NUM_FIELDS = NUM_FIELDS
) (
    input  logic                                   tick,
    input  logic [P_NUM_FIELDS-1:0][P_FIELD_W-1:0] now_i,
    input  logic [P_NUM_FIELDS-1:0][P_FIELD_W-1:0] alarm_i,
    output logic                                   hit_o
);

    logic [P_NUM_FIELDS-1:0] field_eq;

    // Every field takes part; no don't-care masking
    for (genvar g = 0; g < P_NUM_FIELDS; g++) begin : g_cmp
        assign field_eq[g] = (now_i[g] == alarm_i[g]);
    end

    assign hit_o = tick && (&field_eq);

endmodule

// File: rtl/pwroff_latch.sv
module pwroff_latch (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic st_o,
    output logic off_o
);

    // Status: a new match outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            st_o <= 1'b0;
        end else if (hit_i) begin
            st_o <= 1'b1;
        end else if (clr_i) begin
            st_o <= 1'b0;
        end
    end

    // Power-off is sticky until reset
    always_ff @(posedge clk) begin
        if (rst) begin
            off_o <= 1'b0;
        end else if (hit_i && arm_i) begin
            off_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pwroff_alarm_ctrl.sv
module pwroff_alarm_ctrl
    import pwroff_alarm_pkg::*;
#(
    parameter int P_FIELD_W    = FIELD_W,
    parameter int P_NUM_FIELDS = NUM_FIELDS,
    parameter int P_DATA_W     = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [P_FIELD_W-1:0]  cur_sec,
    input  logic [P_FIELD_W-1:0]  cur_min,
    input  logic [P_FIELD_W-1:0]  cur_hour,
    input  logic [P_FIELD_W-1:0]  cur_day,
    input  logic [P_FIELD_W-1:0]  cur_mon,
    input  logic [P_FIELD_W-1:0]  cur_year,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [P_DATA_W-1:0]   reg_wdata,
    input  logic [P_DATA_W/8-1:0] reg_wstrb,
    output logic [P_DATA_W-1:0]   reg_rdata,
    output logic                  pwr_en,
    output logic                  irq
);

    logic [P_NUM_FIELDS-1:0][P_FIELD_W-1:0] now_vec;
    logic [P_NUM_FIELDS-1:0][P_FIELD_W-1:0] alarm_vec;
    logic arm_q, ie_q, clr_req, match_hit, st_q, off_q;

    // Field index order: seconds, minutes, hours, day, month, year
    assign now_vec = {cur_year, cur_mon, cur_day, cur_hour, cur_min, cur_sec};

    pwroff_regfile #(
        .P_FIELD_W    (P_FIELD_W),
        .P_NUM_FIELDS (P_NUM_FIELDS),
        .P_DATA_W     (P_DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wstrb (reg_wstrb),
        .st_i      (st_q),
        .reg_rdata (reg_rdata),
        .alarm_o   (alarm_vec),
        .arm_o     (arm_q),
        .ie_o      (ie_q),
        .clr_o     (clr_req)
    );

    pwroff_match #(
        .P_FIELD_W    (P_FIELD_W),
        .P_NUM_FIELDS (P_NUM_FIELDS)
    ) match_i (
        .tick    (tick),
        .now_i   (now_vec),
        .alarm_i (alarm_vec),
        .hit_o   (match_hit)
    );

    pwroff_latch latch_i (
        .clk   (clk),
        .rst   (rst),
        .hit_i (match_hit),
        .arm_i (arm_q),
        .clr_i (clr_req),
        .st_o  (st_q),
        .off_o (off_q)
    );

    assign pwr_en = ~off_q;
    assign irq    = st_q & ie_q;

endmodule

// File: rtl/pwroff_alarm_chk.sv
module pwroff_alarm_chk
    import pwroff_alarm_pkg::*;
#(
    parameter int P_DATA_W = DATA_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  match_hit,
    input logic                  arm_q,
    input logic                  ie_q,
    input logic                  st_q,
    input logic                  pwr_en,
    input logic                  irq,
    input logic                  reg_we,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [P_DATA_W-1:0]   reg_wdata,
    input logic [P_DATA_W/8-1:0] reg_wstrb
);

    assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        match_hit |=> st_q);

    assert_flag_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q) |-> $past(match_hit));

    assert_armed_match_off_R4: assert property (@(posedge clk) disable iff (rst)
        (match_hit && arm_q) |=> !pwr_en);

    assert_off_needs_arm_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> ($past(arm_q) && $past(match_hit)));

    assert_off_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !pwr_en);

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q && !match_hit && reg_we && reg_addr == STAT_ADDR &&
         reg_wstrb[STAT_BIT/8] && reg_wdata[STAT_BIT]) |=> !st_q);

    assert_ie_partial_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == IE_ADDR && !(&reg_wstrb)) |=> $stable(ie_q));

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> st_q);

endmodule

bind pwroff_alarm_ctrl pwroff_alarm_chk #(.P_DATA_W(P_DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .match_hit (match_hit),
    .arm_q     (arm_q),
    .ie_q      (ie_q),
    .st_q      (st_q),
    .pwr_en    (pwr_en),
    .irq       (irq),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wstrb (reg_wstrb)
);

// File: tb/pwroff_alarm_ctrl_tb_top.sv
module pwroff_alarm_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [7:0]  cur [6];
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_wstrb = '0;
    logic [31:0] reg_rdata;
    logic        pwr_en, irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] alm [6];

    always #2 clk = ~clk;

    pwroff_alarm_ctrl dut_i (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
        .cur_day(cur[3]), .cur_mon(cur[4]), .cur_year(cur[5]),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata),
        .pwr_en(pwr_en), .irq(irq)
    );

    function automatic logic [7:0] field_addr(input int i);
        return 8'h80 + 8'(4 * i);
    endfunction

    function automatic logic [7:0] rand_bcd(input int unsigned maxv);
        int unsigned v;
        v = $urandom_range(maxv);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic all_equal();
        for (int i = 0; i < 6; i++) if (cur[i] != alm[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
        @(negedge clk);
        reg_we = 1'b0; reg_wstrb = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_alarm();
        for (int i = 0; i < 6; i++) wr(field_addr(i), {24'hFFFFFF, alm[i]}, 4'hF);
    endtask

    task automatic stat_flag(output logic f);
        logic [31:0] d;
        rd(8'hA0, d);
        f = d[7];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        f;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 6; i++) cur[i] = 8'h00;
        do_reset();

        // R1: reset state
        check("R1 pwr_en", {31'b0, pwr_en}, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 6; i++) begin
            rd(field_addr(i), d);
            check("R1 compare byte", d, 32'h0);
        end
        rd(8'h98, d); check("R1 arm reg", d, 32'h0);
        rd(8'h9C, d); check("R1 ie reg", d, 32'h0);
        rd(8'hA0, d); check("R1 status reg", d, 32'h0);

        // R2: compare bytes readback, upper bits zero
        alm = '{8'h45, 8'h30, 8'h23, 8'h28, 8'h12, 8'h99};
        load_alarm();
        for (int i = 0; i < 6; i++) begin
            rd(field_addr(i), d);
            check("R2 compare byte readback", d, {24'h0, alm[i]});
        end

        // R8: partial write to ie ignored, full write takes effect
        wr(8'h9C, 32'h0000_0010, 4'h1);
        rd(8'h9C, d); check("R8 ie partial write ignored", d, 32'h0);
        wr(8'h9C, 32'h0000_0010, 4'hF);
        rd(8'h9C, d); check("R8 ie full write", d, 32'h10);

        // R3: no tick, equal time -> no flag
        for (int i = 0; i < 6; i++) cur[i] = alm[i];
        repeat (3) @(negedge clk);
        stat_flag(f); check("R3 no tick no flag", {31'b0, f}, 32'h0);

        // R3: each single differing field blocks the match
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 6; i++) cur[i] = alm[i];
            cur[k] = alm[k] ^ 8'h01;
            pulse_tick();
            stat_flag(f); check("R3 one field differs", {31'b0, f}, 32'h0);
            check("R5 pwr_en unarmed", {31'b0, pwr_en}, 32'h1);
        end

        // R3/R5/R7/R8: random mix, arm clear
        for (int n = 0; n < 40; n++) begin
            logic exp_m;
            if ((n % 8) == 0) begin
                alm = '{rand_bcd(59), rand_bcd(59), rand_bcd(23),
                        8'(rand_bcd(27) + 8'h01), 8'(rand_bcd(8) + 8'h01), rand_bcd(99)};
                load_alarm();
            end
            cur = '{rand_bcd(59), rand_bcd(59), rand_bcd(23),
                    rand_bcd(28), rand_bcd(12), rand_bcd(99)};
            if ($urandom_range(1) == 1) begin
                for (int i = 0; i < 6; i++) cur[i] = alm[i];
                if ($urandom_range(3) == 0) begin
                    int unsigned k;
                    k = $urandom_range(5);
                    cur[k] = cur[k] ^ 8'h10;
                end
            end
            exp_m = all_equal();
            pulse_tick();
            #1;
            check("R8 irq follows flag and enable", {31'b0, irq}, {31'b0, exp_m});
            stat_flag(f); check("R3 random match flag", {31'b0, f}, {31'b0, exp_m});
            check("R5 pwr_en stays on unarmed", {31'b0, pwr_en}, 32'h1);
            wr(8'hA0, 32'h80, 4'h1);
            stat_flag(f); check("R7 w1c clears", {31'b0, f}, 32'h0);
        end

        // R7: write 0 keeps flag; simultaneous set and clear keeps flag
        for (int i = 0; i < 6; i++) cur[i] = alm[i];
        pulse_tick();
        wr(8'hA0, 32'h0, 4'hF);
        stat_flag(f); check("R7 write zero keeps flag", {31'b0, f}, 32'h1);
        wr(8'hA0, 32'h80, 4'h1);
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 8'hA0; reg_wdata = 32'h80; reg_wstrb = 4'h1;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0; reg_wstrb = '0;
        stat_flag(f); check("R7 set beats clear", {31'b0, f}, 32'h1);
        wr(8'hA0, 32'h80, 4'h1);

        // R8: disable irq with full write, flag alone does not raise irq
        wr(8'h9C, 32'h0, 4'hF);
        pulse_tick();
        #1 check("R8 irq off when disabled", {31'b0, irq}, 32'h0);
        wr(8'hA0, 32'h80, 4'h1);

        // R4: arm and match -> power off next cycle
        wr(8'h98, 32'h0001_0000, 4'h4);
        rd(8'h98, d); check("R4 arm readback", d, 32'h0001_0000);
        check("R4 pwr_en before match", {31'b0, pwr_en}, 32'h1);
        @(negedge clk);
        tick = 1'b1;
        #1 check("R4 pwr_en not yet off", {31'b0, pwr_en}, 32'h1);
        @(negedge clk);
        tick = 1'b0;
        check("R4 pwr_en off after match", {31'b0, pwr_en}, 32'h0);

        // R6: sticky until reset
        wr(8'hA0, 32'h80, 4'h1);
        wr(8'h98, 32'h0, 4'hF);
        repeat (4) @(negedge clk);
        check("R6 pwr_en stays off", {31'b0, pwr_en}, 32'h0);
        do_reset();
        check("R6 pwr_en restored by reset", {31'b0, pwr_en}, 32'h1);
        rd(8'h80, d); check("R1 compare cleared by reset", d, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule